// File: doc/BRIEF.md
# Flash Identification Probe Engine

This block reads the identity of a byte-wide parallel flash device. When started, it drives an unlock-and-enter command sequence on a simple write/read bus and then reads the manufacturer byte and the device byte. If either byte is the continuation marker 0x7F, the block reads one more byte from a second location and forms a 16-bit identifier. It then drives the command sequence that returns the device to normal mode. At the end it compares both identifiers with expected values supplied on its inputs and reports a parity-check flag on the manufacturer byte.

Delays between bus cycles are counted in clock cycles. A short step delay follows each of the first two writes of a sequence. A longer settle delay follows the third write. A timing-select input picks the settle delays: an explicit count taken from an input, no delay at all, built-in default counts, or an invalid setting. An invalid setting ends the run at once with no bus access. The results stay on the outputs from the done pulse until the next accepted start.

Top module: `fprobe_top`

## Requirements
- R1: The enter sequence consists of three single-cycle writes, in this order: 0xAA to address 0x5555, 0x55 to address 0x2AAA, 0x90 to address 0x5555. `bus_we` and `bus_re` are never high in the same cycle.
- R2: After the reads, the exit sequence consists of three single-cycle writes, in this order: 0xAA to 0x5555, 0x55 to 0x2AAA, 0xF0 to 0x5555.
- R3: The block reads address 0 (manufacturer) and then address 1 (device) in consecutive cycles. If the byte from address 0 is 0x7F, it also reads 0x100 and the manufacturer ID becomes {0x7F, byte}. If the byte from address 1 is 0x7F, it then reads 0x101 and the device ID becomes {0x7F, byte}. Otherwise an ID is the zero-extended byte. A continuation byte that is itself 0x7F is not extended again.
- R4: When a sequence's settle delay is nonzero, each of its first two writes is followed by `STEP_CYC` idle bus cycles. When the settle delay is zero, no step delay is inserted.
- R5: The third write of each sequence is followed by the settle delay, in idle cycles, before the next bus cycle (enter) or before `done` (exit). `timing_sel` = 0 uses `dly_cfg` for both delays. 1 uses zero for both. 2 uses `DEF_ENTER_CYC` and `DEF_EXIT_CYC`.
- R6: `timing_sel` = 3 is invalid. A start with this setting makes no bus access, raises `done` with `aborted` = 1 in the next cycle, and clears the IDs, `parity_err` and `id_match`.
- R7: `parity_err` is 1 exactly when the low byte of the manufacturer ID has an even number of set bits.
- R8: `id_match` is 1 only when the manufacturer ID equals `exp_mfr` and the device ID equals `exp_dev`. Both are compared at completion.
- R9: `done` is a one-cycle pulse. `busy` is high from the cycle after an accepted start through the done cycle. A start while busy is ignored. The result outputs do not change between `done` and the next accepted start.
- R10: After reset, the bus strobes, `busy`, `done`, `aborted`, the IDs and both flags are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a probe (accepted when idle) |
| timing_sel | input | 2 | 0 explicit, 1 no delay, 2 defaults, 3 invalid |
| dly_cfg | input | DW | Explicit settle delay in cycles (timing_sel 0) |
| exp_mfr | input | 16 | Expected manufacturer ID |
| exp_dev | input | 16 | Expected device ID |
| bus_rdata | input | 8 | Read data, sampled at the end of a read cycle |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | 8 | Bus write data |
| bus_we | output | 1 | Write strobe, one cycle per write |
| bus_re | output | 1 | Read strobe, one cycle per read |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle completion pulse |
| aborted | output | 1 | Last run rejected an invalid timing setting |
| mfr_id | output | 16 | Manufacturer ID |
| dev_id | output | 16 | Device ID |
| parity_err | output | 1 | Manufacturer low byte fails odd parity |
| id_match | output | 1 | Both IDs equal the expected values |

## Verification
Each bus cycle lasts one clock. The gap between two consecutive bus cycles is 1 plus the inserted delay: `STEP_CYC` after the first or second write, the settle count after the third write, and none between reads. `done` rises 1 plus the exit settle count cycles after the last exit write, and the results are registered on that same edge. The bench sampler records every strobe and the done pulse at the falling edge, each with its cycle number. The bench rebuilds the expected gap list from the timing setting and compares it with the recorded cycle differences, then reads the results once `done` has been seen. An abort is checked by the absence of any recorded strobe and by a done pulse in the cycle right after start.

// File: rtl/fprobe_pkg.sv
// Package: shared state encoding, timing-select codes and bus command constants
// for the flash identification probe. Assumes 16-bit command addresses.
package fprobe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WR   = 3'd1,
        ST_WAIT = 3'd2,
        ST_RD   = 3'd3,
        ST_FIN  = 3'd4
    } probe_st_e;

    typedef enum logic [1:0] {
        TSEL_EXPLICIT = 2'd0,
        TSEL_NONE     = 2'd1,
        TSEL_DEFAULT  = 2'd2,
        TSEL_BAD      = 2'd3
    } tsel_e;

    localparam logic [15:0] ADR_UNLK_A = 16'h5555;
    localparam logic [15:0] ADR_UNLK_B = 16'h2AAA;
    localparam logic [15:0] ADR_EXT    = 16'h0100;
    localparam logic [7:0]  CMD_KEY_A  = 8'hAA;
    localparam logic [7:0]  CMD_KEY_B  = 8'h55;
    localparam logic [7:0]  CMD_ID_ON  = 8'h90;
    localparam logic [7:0]  CMD_ID_OFF = 8'hF0;
    localparam logic [7:0]  ID_CONT    = 8'h7F;

endpackage

// File: rtl/fprobe_tdec.sv
// Timing decoder: turns the timing-select code into enter and exit settle
// counts and a validity flag. Purely combinational; the caller latches it.
module fprobe_tdec #(
    parameter int DW            = 16,
    parameter int DEF_ENTER_CYC = 20,
    parameter int DEF_EXIT_CYC  = 6
) (
    input  logic [1:0]    sel,
    input  logic [DW-1:0] cfg,
    output logic [DW-1:0] enter_dly,
    output logic [DW-1:0] exit_dly,
    output logic          valid
);
    import fprobe_pkg::*;

    localparam logic [DW-1:0] DEF_ENT = DW'(DEF_ENTER_CYC);
    localparam logic [DW-1:0] DEF_EXT = DW'(DEF_EXIT_CYC);

    // Select the settle counts for each timing mode.
    always_comb begin
        enter_dly = '0;
        exit_dly  = '0;
        valid     = 1'b1;
        case (tsel_e'(sel))
            TSEL_EXPLICIT: begin
                enter_dly = cfg;
                exit_dly  = cfg;
            end
            TSEL_NONE: begin
                enter_dly = '0;
                exit_dly  = '0;
            end
            TSEL_DEFAULT: begin
                enter_dly = DEF_ENT;
                exit_dly  = DEF_EXT;
            end
            default: valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/fprobe_dlycnt.sv
// Delay counter: loaded with N, it flags expiry in its Nth cycle after load.
// Assumes N >= 1 whenever load is asserted.
module fprobe_dlycnt #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    output logic          expire
);
    logic [DW-1:0] cnt_q;

    // Load on request, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // The final counted cycle is the one holding a count of one.
    assign expire = (cnt_q == DW'(1));
endmodule

// File: rtl/fprobe_oddpar.sv
// Odd-parity folder: halves the vector by XOR until one bit remains.
// Result is 1 when the input has an odd number of set bits. W is a power of two.
module fprobe_oddpar #(
    parameter int W = 8
) (
    input  logic [W-1:0] din,
    output logic         odd
);
    // Fold the upper half onto the lower half repeatedly.
    always_comb begin
        logic [W-1:0] acc;
        acc = din;
        for (int sh = W / 2; sh > 0; sh = sh / 2) begin
            acc = acc ^ (acc >> sh);
        end
        odd = acc[0];
    end
endmodule

// File: rtl/fprobe_seq.sv
// Probe sequencer: drives the enter writes, the ID reads with optional
// continuation reads, and the exit writes, inserting step and settle delays.
// Assumes AW >= 16 and that bus_rdata is valid in the cycle bus_re is high.
module fprobe_seq #(
    parameter int AW       = 16,
    parameter int DW       = 16,
    parameter int STEP_CYC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          cfg_valid,
    input  logic [DW-1:0] enter_dly,
    input  logic [DW-1:0] exit_dly,
    input  logic [7:0]    bus_rdata,
    output logic [AW-1:0] bus_addr,
    output logic [7:0]    bus_wdata,
    output logic          bus_we,
    output logic          bus_re,
    output logic [15:0]   mfr_w,
    output logic [15:0]   dev_w,
    output logic          go_fin,
    output logic          abort_fin,
    output logic          in_fin,
    output logic          busy
);
    import fprobe_pkg::*;

    localparam logic [DW-1:0] STEP_D = DW'(STEP_CYC);

    probe_st_e     st_q, st_d;
    logic          phase_q, phase_d;      // 0 = enter sequence, 1 = exit sequence
    logic [1:0]    idx_q, idx_d;
    logic [DW-1:0] ent_q, ext_q;
    logic [DW-1:0] cur_dly, gap;
    logic          adv, to_exit, dly_load, expire;

    fprobe_dlycnt #(.DW(DW)) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dly_load),
        .load_val (gap),
        .expire   (expire)
    );

    // Gap after the current write: settle after the third, step otherwise.
    always_comb begin
        cur_dly = phase_q ? ext_q : ent_q;
        if (idx_q == 2'd2) begin
            gap = cur_dly;
        end else begin
            gap = (cur_dly != '0) ? STEP_D : '0;
        end
    end

    // Next-state, bus drive and completion strobes.
    always_comb begin
        st_d      = st_q;
        phase_d   = phase_q;
        idx_d     = idx_q;
        bus_addr  = '0;
        bus_wdata = '0;
        bus_we    = 1'b0;
        bus_re    = 1'b0;
        dly_load  = 1'b0;
        adv       = 1'b0;
        to_exit   = 1'b0;
        go_fin    = 1'b0;
        abort_fin = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (start) begin
                    if (cfg_valid) begin
                        st_d    = ST_WR;
                        phase_d = 1'b0;
                        idx_d   = 2'd0;
                    end else begin
                        st_d      = ST_FIN;
                        go_fin    = 1'b1;
                        abort_fin = 1'b1;
                    end
                end
            end
            ST_WR: begin
                bus_we = 1'b1;
                case (idx_q)
                    2'd0: begin
                        bus_addr  = AW'(ADR_UNLK_A);
                        bus_wdata = CMD_KEY_A;
                    end
                    2'd1: begin
                        bus_addr  = AW'(ADR_UNLK_B);
                        bus_wdata = CMD_KEY_B;
                    end
                    default: begin
                        bus_addr  = AW'(ADR_UNLK_A);
                        bus_wdata = phase_q ? CMD_ID_OFF : CMD_ID_ON;
                    end
                endcase
                if (gap != '0) begin
                    dly_load = 1'b1;
                    st_d     = ST_WAIT;
                end else begin
                    adv = 1'b1;
                end
            end
            ST_WAIT: begin
                if (expire) begin
                    adv = 1'b1;
                end
            end
            ST_RD: begin
                bus_re   = 1'b1;
                bus_addr = AW'({7'd0, idx_q[1], 7'd0, idx_q[0]});
                case (idx_q)
                    2'd0: idx_d = 2'd1;
                    2'd1: begin
                        if (mfr_w[7:0] == ID_CONT) begin
                            idx_d = 2'd2;
                        end else if (bus_rdata == ID_CONT) begin
                            idx_d = 2'd3;
                        end else begin
                            to_exit = 1'b1;
                        end
                    end
                    2'd2: begin
                        if (dev_w[7:0] == ID_CONT) begin
                            idx_d = 2'd3;
                        end else begin
                            to_exit = 1'b1;
                        end
                    end
                    default: to_exit = 1'b1;
                endcase
            end
            ST_FIN: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase

        if (to_exit) begin
            st_d    = ST_WR;
            phase_d = 1'b1;
            idx_d   = 2'd0;
        end

        if (adv) begin
            if (idx_q != 2'd2) begin
                idx_d = idx_q + 2'd1;
                st_d  = ST_WR;
            end else if (!phase_q) begin
                st_d  = ST_RD;
                idx_d = 2'd0;
            end else begin
                st_d   = ST_FIN;
                go_fin = 1'b1;
            end
        end
    end

    // State, sequence position and latched delays.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            phase_q <= 1'b0;
            idx_q   <= 2'd0;
            ent_q   <= '0;
            ext_q   <= '0;
        end else begin
            st_q    <= st_d;
            phase_q <= phase_d;
            idx_q   <= idx_d;
            if (st_q == ST_IDLE && start) begin
                ent_q <= enter_dly;
                ext_q <= exit_dly;
            end
        end
    end

    // Capture ID bytes, shifting in the continuation byte when read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mfr_w <= '0;
            dev_w <= '0;
        end else if (st_q == ST_RD) begin
            case (idx_q)
                2'd0:    mfr_w <= {8'h00, bus_rdata};
                2'd1:    dev_w <= {8'h00, bus_rdata};
                2'd2:    mfr_w <= {mfr_w[7:0], bus_rdata};
                default: dev_w <= {dev_w[7:0], bus_rdata};
            endcase
        end
    end

    assign in_fin = (st_q == ST_FIN);
    assign busy   = (st_q != ST_IDLE);
endmodule

// File: rtl/fprobe_top.sv
// Flash identification probe top: decodes timing, runs the sequencer and
// registers IDs, parity flag and match result on completion.
// Assumes expected IDs are held stable until done.
module fprobe_top #(
    parameter int AW            = 16,
    parameter int DW            = 16,
    parameter int STEP_CYC      = 4,
    parameter int DEF_ENTER_CYC = 20,
    parameter int DEF_EXIT_CYC  = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    timing_sel,
    input  logic [DW-1:0] dly_cfg,
    input  logic [15:0]   exp_mfr,
    input  logic [15:0]   exp_dev,
    input  logic [7:0]    bus_rdata,
    output logic [AW-1:0] bus_addr,
    output logic [7:0]    bus_wdata,
    output logic          bus_we,
    output logic          bus_re,
    output logic          busy,
    output logic          done,
    output logic          aborted,
    output logic [15:0]   mfr_id,
    output logic [15:0]   dev_id,
    output logic          parity_err,
    output logic          id_match
);
    logic [DW-1:0] enter_dly, exit_dly;
    logic          cfg_valid, go_fin, abort_fin, mfr_odd;
    logic [15:0]   mfr_w, dev_w;

    fprobe_tdec #(
        .DW            (DW),
        .DEF_ENTER_CYC (DEF_ENTER_CYC),
        .DEF_EXIT_CYC  (DEF_EXIT_CYC)
    ) u_tdec (
        .sel       (timing_sel),
        .cfg       (dly_cfg),
        .enter_dly (enter_dly),
        .exit_dly  (exit_dly),
        .valid     (cfg_valid)
    );

    fprobe_seq #(
        .AW       (AW),
        .DW       (DW),
        .STEP_CYC (STEP_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cfg_valid (cfg_valid),
        .enter_dly (enter_dly),
        .exit_dly  (exit_dly),
        .bus_rdata (bus_rdata),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .mfr_w     (mfr_w),
        .dev_w     (dev_w),
        .go_fin    (go_fin),
        .abort_fin (abort_fin),
        .in_fin    (done),
        .busy      (busy)
    );

    fprobe_oddpar #(.W(8)) u_par (
        .din (mfr_w[7:0]),
        .odd (mfr_odd)
    );

    // Register results on the edge that enters the done cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mfr_id     <= '0;
            dev_id     <= '0;
            parity_err <= 1'b0;
            id_match   <= 1'b0;
            aborted    <= 1'b0;
        end else if (go_fin) begin
            if (abort_fin) begin
                mfr_id     <= '0;
                dev_id     <= '0;
                parity_err <= 1'b0;
                id_match   <= 1'b0;
                aborted    <= 1'b1;
            end else begin
                mfr_id     <= mfr_w;
                dev_id     <= dev_w;
                parity_err <= ~mfr_odd;
                id_match   <= (mfr_w == exp_mfr) && (dev_w == exp_dev);
                aborted    <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fprobe_chk.sv
// Checker: temporal properties of the probe engine, bound to fprobe_top.
// Tracks the first-pass ID bytes seen on the bus to judge continuation reads.
module fprobe_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [1:0]    timing_sel,
    input logic [15:0]   exp_mfr,
    input logic [15:0]   exp_dev,
    input logic [7:0]    bus_rdata,
    input logic [AW-1:0] bus_addr,
    input logic          bus_we,
    input logic          bus_re,
    input logic          busy,
    input logic          done,
    input logic          aborted,
    input logic [15:0]   mfr_id,
    input logic [15:0]   dev_id,
    input logic          parity_err,
    input logic          id_match
);
    logic [7:0] seen_m, seen_d;

    // Remember the bytes returned from addresses 0 and 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_m <= '0;
            seen_d <= '0;
        end else if (bus_re) begin
            if (bus_addr == AW'(0)) seen_m <= bus_rdata;
            if (bus_addr == AW'(1)) seen_d <= bus_rdata;
        end
    end

    p_bus_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_re));

    p_ext_mfr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == AW'(16'h0100)) |-> (seen_m == 8'h7F));

    p_ext_dev_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == AW'(16'h0101)) |-> (seen_d == 8'h7F));

    p_abort_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && timing_sel == 2'd3) |=> (done && aborted && !bus_we && !bus_re));

    p_parity_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !aborted) |-> (parity_err == ~(^mfr_id[7:0])));

    p_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !aborted) |-> (id_match == ((mfr_id == exp_mfr) && (dev_id == exp_dev))));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(mfr_id) && $stable(dev_id) &&
                               $stable(parity_err) && $stable(id_match)));
endmodule

bind fprobe_top fprobe_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .timing_sel (timing_sel),
    .exp_mfr    (exp_mfr),
    .exp_dev    (exp_dev),
    .bus_rdata  (bus_rdata),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_re     (bus_re),
    .busy       (busy),
    .done       (done),
    .aborted    (aborted),
    .mfr_id     (mfr_id),
    .dev_id     (dev_id),
    .parity_err (parity_err),
    .id_match   (id_match)
);

// File: tb/fprobe_top_tb.sv
// Bench: vector table walked by one loop, then directed reset/abort/busy tests.
module fprobe_top_tb;
    localparam int AW = 16, DW = 16, STEP = 4, DEF_ENT = 20, DEF_EXT = 6;

    typedef struct packed {
        logic [1:0]  sel;
        logic [15:0] dly;
        logic [7:0]  b0, b1, b2, b3;
        logic [15:0] em, ed, xm, xd;
        logic        xpar, xmatch;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VT [NV] = '{
        '{2'd0, 16'd3, 8'h01, 8'hB5, 8'h00, 8'h00, 16'h0001, 16'h00B5, 16'h0001, 16'h00B5, 1'b0, 1'b1},
        '{2'd1, 16'd9, 8'h7F, 8'h20, 8'h9D, 8'h00, 16'h7F9D, 16'h0020, 16'h7F9D, 16'h0020, 1'b0, 1'b1},
        '{2'd2, 16'd0, 8'h03, 8'h7F, 8'h00, 8'h45, 16'h0003, 16'h7F44, 16'h0003, 16'h7F45, 1'b1, 1'b0},
        '{2'd0, 16'd0, 8'h7F, 8'h7F, 8'h0E, 8'h12, 16'h7F0E, 16'h7F12, 16'h7F0E, 16'h7F12, 1'b0, 1'b1},
        '{2'd0, 16'd5, 8'hC2, 8'h11, 8'h00, 8'h00, 16'h00C3, 16'h0011, 16'h00C2, 16'h0011, 1'b0, 1'b0},
        '{2'd1, 16'd0, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b1, 1'b1},
        '{2'd0, 16'd2, 8'h7F, 8'h7F, 8'h7F, 8'h80, 16'h7F7F, 16'h7F81, 16'h7F7F, 16'h7F80, 1'b0, 1'b0}
    };

    logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [1:0]    timing_sel = 2'd0;
    logic [DW-1:0] dly_cfg = '0;
    logic [15:0]   exp_mfr = '0, exp_dev = '0;
    logic [7:0]    bus_rdata, b0 = 8'h00, b1 = 8'h00, b2 = 8'h00, b3 = 8'h00;
    logic [AW-1:0] bus_addr;
    logic [7:0]    bus_wdata;
    logic          bus_we, bus_re, busy, done, aborted, parity_err, id_match;
    logic [15:0]   mfr_id, dev_id;

    int total = 0, bad = 0, cyc = 0, n_ev = 0, n_done = 0, done_cyc = 0;
    logic [AW-1:0] ev_addr [32];
    logic [7:0]    ev_data [32];
    logic          ev_we   [32];
    int            ev_cyc  [32];

    fprobe_top #(.AW(AW), .DW(DW), .STEP_CYC(STEP), .DEF_ENTER_CYC(DEF_ENT),
                 .DEF_EXIT_CYC(DEF_EXT)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .timing_sel(timing_sel),
        .dly_cfg(dly_cfg), .exp_mfr(exp_mfr), .exp_dev(exp_dev),
        .bus_rdata(bus_rdata), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .busy(busy), .done(done),
        .aborted(aborted), .mfr_id(mfr_id), .dev_id(dev_id),
        .parity_err(parity_err), .id_match(id_match));

    always #5 clk = ~clk;

    // Simple device: ID bytes at the four probe locations.
    assign bus_rdata = (bus_addr == 16'h0000) ? b0 :
                       (bus_addr == 16'h0001) ? b1 :
                       (bus_addr == 16'h0100) ? b2 :
                       (bus_addr == 16'h0101) ? b3 : 8'hEE;

    always @(posedge clk) cyc <= cyc + 1;

    // Record bus strobes and done pulses away from the active edge.
    always @(negedge clk) begin
        if (bus_we || bus_re) begin
            if (n_ev < 32) begin
                ev_addr[n_ev] = bus_addr;
                ev_data[n_ev] = bus_wdata;
                ev_we[n_ev]   = bus_we;
                ev_cyc[n_ev]  = cyc;
            end
            n_ev = n_ev + 1;
        end
        if (done) begin
            n_done   = n_done + 1;
            done_cyc = cyc;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic launch(input logic [1:0] sel, input logic [15:0] dly,
                          input logic [15:0] em, input logic [15:0] ed);
        @(negedge clk);
        timing_sel = sel; dly_cfg = dly; exp_mfr = em; exp_dev = ed;
        n_ev = 0; n_done = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000 && n_done == 0; i++) @(negedge clk);
        @(negedge clk);
        chk(n_done == 1, "R9", "single done pulse", n_done, 1);
    endtask

    // Compare recorded bus activity and gaps against the expected sequence.
    task automatic check_run(input vec_t v);
        int ent, ext, es, xs, ne;
        logic [AW-1:0] ea [10];
        logic [7:0]    edt [10];
        logic          ew [10];
        int            eg [10];
        string         er [10];
        bit            ok_en, ok_rd, ok_ex;
        ent = (v.sel == 2'd0) ? int'(v.dly) : (v.sel == 2'd2) ? DEF_ENT : 0;
        ext = (v.sel == 2'd0) ? int'(v.dly) : (v.sel == 2'd2) ? DEF_EXT : 0;
        es = (ent != 0) ? STEP : 0;
        xs = (ext != 0) ? STEP : 0;
        ne = 0;
        ea[ne]=16'h5555; edt[ne]=8'hAA; ew[ne]=1; eg[ne]=0;      er[ne]="R1"; ne++;
        ea[ne]=16'h2AAA; edt[ne]=8'h55; ew[ne]=1; eg[ne]=1+es;   er[ne]="R4"; ne++;
        ea[ne]=16'h5555; edt[ne]=8'h90; ew[ne]=1; eg[ne]=1+es;   er[ne]="R4"; ne++;
        ea[ne]=16'h0000; edt[ne]=8'h00; ew[ne]=0; eg[ne]=1+ent;  er[ne]="R5"; ne++;
        ea[ne]=16'h0001; edt[ne]=8'h00; ew[ne]=0; eg[ne]=1;      er[ne]="R3"; ne++;
        if (v.b0 == 8'h7F) begin
            ea[ne]=16'h0100; edt[ne]=8'h00; ew[ne]=0; eg[ne]=1; er[ne]="R3"; ne++;
        end
        if (v.b1 == 8'h7F) begin
            ea[ne]=16'h0101; edt[ne]=8'h00; ew[ne]=0; eg[ne]=1; er[ne]="R3"; ne++;
        end
        ea[ne]=16'h5555; edt[ne]=8'hAA; ew[ne]=1; eg[ne]=1;      er[ne]="R2"; ne++;
        ea[ne]=16'h2AAA; edt[ne]=8'h55; ew[ne]=1; eg[ne]=1+xs;   er[ne]="R4"; ne++;
        ea[ne]=16'h5555; edt[ne]=8'hF0; ew[ne]=1; eg[ne]=1+xs;   er[ne]="R4"; ne++;
        chk(n_ev == ne, "R3", "bus cycle count", n_ev, ne);
        if (n_ev == ne) begin
            ok_en = 1; ok_rd = 1; ok_ex = 1;
            for (int i = 0; i < ne; i++) begin
                if (ev_we[i] != ew[i] || ev_addr[i] != ea[i] || (ew[i] && ev_data[i] != edt[i])) begin
                    if (i < 3) ok_en = 0;
                    else if (i < ne - 3) ok_rd = 0;
                    else ok_ex = 0;
                end
            end
            chk(ok_en, "R1", "enter writes", {ev_addr[2], ev_data[2]}, {ea[2], edt[2]});
            chk(ok_rd, "R3", "read addresses", ev_addr[ne-4], ea[ne-4]);
            chk(ok_ex, "R2", "exit writes", {ev_addr[ne-1], ev_data[ne-1]}, {ea[ne-1], edt[ne-1]});
            for (int i = 1; i < ne; i++)
                chk(ev_cyc[i] - ev_cyc[i-1] == eg[i], er[i], "gap before bus cycle",
                    ev_cyc[i] - ev_cyc[i-1], eg[i]);
            chk(done_cyc - ev_cyc[ne-1] == 1 + ext, "R5", "exit settle before done",
                done_cyc - ev_cyc[ne-1], 1 + ext);
        end
        chk(mfr_id == v.xm, "R3", "manufacturer id", mfr_id, v.xm);
        chk(dev_id == v.xd, "R3", "device id", dev_id, v.xd);
        chk(parity_err == v.xpar, "R7", "parity flag", parity_err, v.xpar);
        chk(id_match == v.xmatch, "R8", "match flag", id_match, v.xmatch);
        chk(aborted == 1'b0, "R6", "aborted on valid run", aborted, 0);
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL R9 watchdog actual=expired expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] hold_m, hold_d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(!bus_we && !bus_re && !busy && !done && !aborted, "R10", "idle strobes",
            {bus_we, bus_re, busy, done, aborted}, 0);
        chk(mfr_id == 0 && dev_id == 0 && !parity_err && !id_match, "R10", "cleared results",
            {mfr_id, dev_id}, 0);

        for (int k = 0; k < NV; k++) begin
            b0 = VT[k].b0; b1 = VT[k].b1; b2 = VT[k].b2; b3 = VT[k].b3;
            launch(VT[k].sel, VT[k].dly, VT[k].em, VT[k].ed);
            wait_done();
            check_run(VT[k]);
        end

        // R9: results held after done until the next start
        hold_m = mfr_id; hold_d = dev_id;
        b0 = 8'h55; b1 = 8'h66;
        repeat (8) @(negedge clk);
        chk(mfr_id == hold_m && dev_id == hold_d, "R9", "outputs held while idle",
            {mfr_id, dev_id}, {hold_m, hold_d});

        // R6: invalid timing aborts without bus access
        launch(2'd3, 16'd4, 16'h0000, 16'h0000);
        chk(done && aborted, "R6", "done with abort right after start", {done, aborted}, 2'b11);
        wait_done();
        chk(n_ev == 0, "R6", "no bus access on abort", n_ev, 0);
        chk(aborted && !id_match && mfr_id == 0 && dev_id == 0, "R6", "abort clears results",
            {aborted, id_match, mfr_id}, {1'b1, 1'b0, 16'h0});

        // R9: start while busy is ignored
        b0 = 8'h01; b1 = 8'h02;
        launch(2'd1, 16'd0, 16'h0001, 16'h0002);
        chk(busy, "R9", "busy after accepted start", busy, 1);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_done();
        repeat (10) @(negedge clk);
        chk(n_ev == 8, "R9", "restart while busy ignored", n_ev, 8);
        chk(n_done == 1 && !busy, "R9", "one completion only", n_done, 1);
        chk(id_match && !aborted, "R8", "match after valid run clears abort", {id_match, aborted}, 2'b10);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule